// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter with two clock sources. The first is an internal instruction tick at one quarter of the system clock rate. The second is an external clock pin. The chosen source first passes through a prescaler that divides by 1, 2, 4 or 8. The prescaler is a 3-bit count of input events, and the selected count bit serves as its output level.

With the external source, the prescaled level can take one of two paths. The synchronized path re-times the level through two flip-flops that sample only on the second and fourth phases of each four-phase instruction cycle, then passes it through a rising-edge detector. The asynchronous path uses the prescaler's own carry event directly. A sleep input stops the counter only on the synchronized external path. The prescaler keeps counting during sleep.

Software sees the count as two bytes. It can write either byte, and any byte write also clears the prescaler. A sticky flag is raised when the count rolls over from 0xFFFF to 0x0000, and it stays set until software writes it.

Top module: `presc_timer16`

## Requirements
- R1: With `src_ext`=0, the prescaler input is one tick per four system clocks. With prescale 1, a window of 4·T enabled clocks adds exactly T to the count. `sync_n` has no effect in this mode.
- R2: `pre_sel` encodes the ratio as 00→1, 01→2, 10→4, 11→8. For ratio N>1, one increment occurs each time bit log2(N)−1 of the 3-bit prescaler count rises from 0 to 1. For ratio 1, every input event increments the count.
- R3: With `src_ext`=1, each rising edge of `ext_clk` is one prescaler input event.
- R4: With `src_ext`=1 and `sync_n`=0, the prescaled level is synchronized before counting. With `sync_n`=1, it is counted without synchronization. Both paths give the same total for the same edges.
- R5: With `src_ext`=1, `sync_n`=0 and `sleep`=1, the count does not change. The prescaler still advances on each edge.
- R6: `sleep` has no effect on the internal mode or on the asynchronous external mode.
- R7: While `run_en`=0, neither the count nor the prescaler advances.
- R8: `wr_lo`/`wr_hi` load `wr_data` into the low/high byte, visible after the next clock edge. Either write clears the prescaler count.
- R9: An increment from 0xFFFF to 0x0000 sets `ovf_flag`. The flag then holds until `flag_wr` loads `flag_wdata` into it: 0 clears it and 1 sets it.
- R10: After reset, the count, the flag and the prescaler are all zero.
- R11: Without a byte write, the count changes by at most +1 per system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ext_clk | input | 1 | External count clock |
| run_en | input | 1 | Enables all counting |
| src_ext | input | 1 | 0: internal tick, 1: external clock |
| sync_n | input | 1 | External path: 0 synchronized, 1 asynchronous |
| pre_sel | input | 2 | Prescale ratio select |
| sleep | input | 1 | Freezes the counter on the synchronized external path |
| wr_lo | input | 1 | Load low byte |
| wr_hi | input | 1 | Load high byte |
| wr_data | input | 8 | Byte write data |
| flag_wr | input | 1 | Load overflow flag |
| flag_wdata | input | 1 | Value for overflow flag |
| cnt_lo | output | 8 | Count bits 7..0 |
| cnt_hi | output | 8 | Count bits 15..8 |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
The properties assume that `ext_clk` stays high and low for at least four system clocks each. This lets the phase-gated sampler see every level change, so no edge is lost or counted twice.

The properties also assume that mode, ratio and sleep change only while `run_en` is low. This keeps a stale synchronizer state from producing a count.

The stimulus meets both assumptions. External pulses are four clocks high and four clocks low. Every configuration change and byte load happens with counting disabled, followed by a settle gap before counting is enabled again. Random scenarios draw the mode, ratio, sleep, start value and run length from a seeded generator, and these are mixed with directed rollover, sleep and prescaler-clear cases.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int PRE_W  = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef struct packed {
        logic ext_q;
        logic ext_prev;
    } pin_state_t;

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_state_t;
endpackage

// File: rtl/ptmr_phase.sv
// Four-phase sequencer: one tick per instruction cycle, sample strobes on phases 2 and 4.
module ptmr_phase
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic tick_o,
    output logic strobe_o
);
    phase_e ph_d, ph_q;

    always_comb begin
        ph_d     = phase_e'(ph_q + 2'd1);
        tick_o   = (ph_q == PH_Q4);
        strobe_o = (ph_q == PH_Q2) || (ph_q == PH_Q4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_Q1;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/ptmr_prescaler.sv
// Divide-by-2^sel event counter; output level is a count bit, event is its rising step.
module ptmr_prescaler #(
    parameter int PRE_W = ptmr_pkg::PRE_W,
    parameter int SEL_W = ptmr_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_evt,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic             raw_lvl,
    output logic             lvl_o,
    output logic             evt_o
);
    logic [PRE_W-1:0] pcnt_d, pcnt_q;
    logic [PRE_W-1:0] pcnt_inc;

    always_comb begin
        pcnt_inc = pcnt_q + {{(PRE_W-1){1'b0}}, 1'b1};
        pcnt_d   = pcnt_q;
        if (clr)         pcnt_d = '0;
        else if (in_evt) pcnt_d = pcnt_inc;

        lvl_o = raw_lvl;
        evt_o = in_evt;
        for (int b = 0; b < PRE_W; b++) begin
            if (int'(sel) == b + 1) begin
                lvl_o = pcnt_q[b];
                evt_o = in_evt && pcnt_inc[b] && !pcnt_q[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/ptmr_sync.sv
// Two-stage phase-gated synchronizer followed by a rising-edge detector.
module ptmr_sync
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic lvl,
    output logic pulse_o
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.s1 = lvl;
            st_d.s2 = st_q.s1;
        end
        pulse_o = strobe && st_q.s1 && !st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ptmr_counter.sv
// Byte-loadable up-counter with sticky rollover flag.
module ptmr_counter #(
    parameter int CNT_W  = ptmr_pkg::CNT_W,
    parameter int BYTE_W = ptmr_pkg::BYTE_W,
    localparam int NB    = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic [NB-1:0]     wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } ctr_t;

    ctr_t st_d, st_q;
    logic any_wr;
    logic roll;

    always_comb begin
        st_d   = st_q;
        any_wr = |wr_en;
        roll   = &st_q.cnt;
        if (any_wr) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_en[b]) st_d.cnt[b*BYTE_W +: BYTE_W] = wr_data;
            end
        end else if (inc) begin
            st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
        if (flag_wr)                  st_d.flag = flag_wdata;
        if (inc && !any_wr && roll)   st_d.flag = 1'b1;
        cnt_o  = st_q.cnt;
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/presc_timer16.sv
module presc_timer16
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = ptmr_pkg::CNT_W,
    parameter int BYTE_W = ptmr_pkg::BYTE_W,
    parameter int PRE_W  = ptmr_pkg::PRE_W,
    parameter int SEL_W  = ptmr_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              run_en,
    input  logic              src_ext,
    input  logic              sync_n,
    input  logic [SEL_W-1:0]  pre_sel,
    input  logic              sleep,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              ovf_flag
);
    localparam int NB = CNT_W / BYTE_W;

    pin_state_t pin_d, pin_q;
    logic tick, strobe;
    logic ext_rise, in_evt, pre_lvl, pre_evt, sync_pulse, inc;
    logic [NB-1:0]    wr_en;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        pin_d.ext_q    = ext_clk;
        pin_d.ext_prev = pin_q.ext_q;
        ext_rise       = pin_q.ext_q && !pin_q.ext_prev;
        in_evt         = run_en && (src_ext ? ext_rise : tick);
        wr_en          = '0;
        wr_en[0]       = wr_lo;
        wr_en[NB-1]    = wr_hi;
        if (!src_ext || sync_n) inc = pre_evt;
        else                    inc = sync_pulse && run_en && !sleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    ptmr_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_o   (tick),
        .strobe_o (strobe)
    );

    ptmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_evt  (in_evt),
        .clr     (wr_lo || wr_hi),
        .sel     (pre_sel),
        .raw_lvl (pin_q.ext_q),
        .lvl_o   (pre_lvl),
        .evt_o   (pre_evt)
    );

    ptmr_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .lvl     (pre_lvl),
        .pulse_o (sync_pulse)
    );

    ptmr_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (inc),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .cnt_o      (cnt),
        .flag_o     (ovf_flag)
    );

    assign cnt_lo = cnt[BYTE_W-1:0];
    assign cnt_hi = cnt[CNT_W-1 -: BYTE_W];
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic       src_ext,
    input logic       sync_n,
    input logic       sleep,
    input logic       wr_lo,
    input logic       wr_hi,
    input logic [7:0] wr_data,
    input logic       flag_wr,
    input logic       flag_wdata,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_hi,
    input logic       ovf_flag
);
    logic [15:0] cw;
    logic        no_wr;
    assign cw    = {cnt_hi, cnt_lo};
    assign no_wr = !wr_lo && !wr_hi;

    assert_halt_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && no_wr) |=> $stable(cw));

    assert_sleep_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext && !sync_n && sleep && no_wr) |=> $stable(cw));

    assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        no_wr |=> (cw == $past(cw)) || (cw == $past(cw) + 16'd1));

    assert_lo_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_lo == $past(wr_data));

    assert_hi_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> cnt_hi == $past(wr_data));

    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cw) == 16'hFFFF) || $past(flag_wr && flag_wdata));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_wr) |=> ovf_flag);
endmodule

bind presc_timer16 ptmr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .src_ext    (src_ext),
    .sync_n     (sync_n),
    .sleep      (sleep),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .wr_data    (wr_data),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .cnt_lo     (cnt_lo),
    .cnt_hi     (cnt_hi),
    .ovf_flag   (ovf_flag)
);

// File: tb/tb_presc_timer16.sv
module tb_presc_timer16;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0, run_en = 1'b0, src_ext = 1'b0, sync_n = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic       sleep = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       flag_wr = 1'b0, flag_wdata = 1'b0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       ovf_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] m_cnt  = 16'd0;
    logic [2:0]  m_pcnt = 3'd0;
    logic        m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    presc_timer16 dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .run_en(run_en),
        .src_ext(src_ext), .sync_n(sync_n), .pre_sel(pre_sel), .sleep(sleep),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        check(req, "count", {16'd0, cnt_hi, cnt_lo}, {16'd0, m_cnt});
        check(req, "flag", {31'd0, ovf_flag}, {31'd0, m_flag});
    endtask

    // One prescaler input event in the reference model
    function automatic void model_input();
        logic [2:0] old;
        bit fire;
        bit gate;
        old    = m_pcnt;
        m_pcnt = m_pcnt + 3'd1;
        fire   = (pre_sel == 2'd0) ||
                 (m_pcnt[int'(pre_sel)-1] && !old[int'(pre_sel)-1]);
        gate   = sleep && src_ext && !sync_n;
        if (fire && !gate) begin
            if (m_cnt == 16'hFFFF) m_flag = 1'b1;
            m_cnt = m_cnt + 16'd1;
        end
    endfunction

    task automatic cfg(bit s, bit sn, logic [1:0] ps, bit slp);
        @(negedge clk);
        run_en = 0; src_ext = s; sync_n = sn; pre_sel = ps; sleep = slp;
        repeat (4) @(negedge clk);
    endtask

    task automatic load(logic [15:0] v);
        @(negedge clk); wr_lo = 1; wr_data = v[7:0];
        @(negedge clk); wr_lo = 0; wr_hi = 1; wr_data = v[15:8];
        @(negedge clk); wr_hi = 0;
        m_cnt = v; m_pcnt = 3'd0;
        repeat (6) @(negedge clk);
    endtask

    task automatic run_int(int ticks);
        @(negedge clk); run_en = 1;
        repeat (4 * ticks) @(negedge clk);
        run_en = 0;
        for (int i = 0; i < ticks; i++) model_input();
        @(negedge clk);
    endtask

    task automatic ext_pulse(bit counted);
        ext_clk = 1; repeat (4) @(negedge clk);
        ext_clk = 0; repeat (4) @(negedge clk);
        if (counted) model_input();
    endtask

    task automatic run_ext(int edges);
        @(negedge clk); run_en = 1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < edges; i++) ext_pulse(1'b1);
        repeat (12) @(negedge clk);
        run_en = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R10");

        // R10/R2: prescaler starts at zero -> first edge at /2 increments
        cfg(1, 1, 2'd1, 0);
        run_ext(1);
        check_state("R10");

        // R1: internal /1, sync bit both ways
        cfg(0, 1, 2'd0, 0); load(16'h0010); run_int(12);
        check_state("R1");
        check("R1", "abs", {16'd0, cnt_hi, cnt_lo}, 32'h001C);
        cfg(0, 0, 2'd0, 0); load(16'h0010); run_int(12);
        check_state("R1");

        // R2: internal /8, 16 ticks; /4, 10 ticks
        cfg(0, 0, 2'd3, 0); load(16'h0100); run_int(16);
        check_state("R2");
        cfg(0, 0, 2'd2, 0); load(16'h0200); run_int(10);
        check_state("R2");

        // R3/R4: synchronized and asynchronous external
        cfg(1, 0, 2'd0, 0); load(16'h0300); run_ext(5);
        check_state("R3");
        check("R4", "sync abs", {16'd0, cnt_hi, cnt_lo}, 32'h0305);
        cfg(1, 1, 2'd0, 0); load(16'h0300); run_ext(5);
        check("R4", "async abs", {16'd0, cnt_hi, cnt_lo}, 32'h0305);
        cfg(1, 0, 2'd2, 0); load(16'h0000); run_ext(9);
        check_state("R4");

        // R5: sleep freezes synchronized path but prescaler keeps going
        cfg(1, 0, 2'd2, 1); load(16'h0000); run_ext(5);
        check("R5", "frozen", {16'd0, cnt_hi, cnt_lo}, 32'h0000);
        cfg(1, 0, 2'd2, 0); run_ext(1);
        check("R5", "prescaler ran", {16'd0, cnt_hi, cnt_lo}, 32'h0001);
        check_state("R5");

        // R6: sleep ignored on async and internal
        cfg(1, 1, 2'd0, 1); load(16'h0040); run_ext(3);
        check("R6", "async", {16'd0, cnt_hi, cnt_lo}, 32'h0043);
        cfg(0, 0, 2'd0, 1); load(16'h0040); run_int(4);
        check("R6", "internal", {16'd0, cnt_hi, cnt_lo}, 32'h0044);

        // R7: disabled -> nothing advances, prescaler held
        cfg(1, 1, 2'd1, 0); load(16'h0500);
        for (int i = 0; i < 3; i++) ext_pulse(1'b0);
        repeat (40) @(negedge clk);
        check("R7", "count off", {16'd0, cnt_hi, cnt_lo}, 32'h0500);
        run_ext(1);
        check("R7", "prescaler held", {16'd0, cnt_hi, cnt_lo}, 32'h0501);

        // R8: write visible next clock, clears prescaler
        cfg(0, 0, 2'd3, 0); load(16'h0000); run_int(3);
        @(negedge clk); wr_lo = 1; wr_data = 8'h34;
        @(negedge clk); wr_lo = 0;
        check("R8", "lo byte", {24'd0, cnt_lo}, 32'h34);
        wr_hi = 1; wr_data = 8'h12;
        @(negedge clk); wr_hi = 0;
        check("R8", "hi byte", {24'd0, cnt_hi}, 32'h12);
        m_cnt = 16'h1234; m_pcnt = 3'd0;
        repeat (4) @(negedge clk);
        run_int(3);
        check("R8", "prescaler cleared", {16'd0, cnt_hi, cnt_lo}, 32'h1234);

        // R9: rollover, sticky, write clears/sets
        cfg(0, 0, 2'd0, 0); load(16'hFFFE); run_int(2);
        check("R9", "wrapped", {16'd0, cnt_hi, cnt_lo}, 32'h0000);
        check("R9", "flag set", {31'd0, ovf_flag}, 32'd1);
        m_flag = 1'b1;
        repeat (20) @(negedge clk);
        check("R9", "flag held", {31'd0, ovf_flag}, 32'd1);
        flag_wr = 1; flag_wdata = 0; @(negedge clk); flag_wr = 0;
        check("R9", "flag cleared", {31'd0, ovf_flag}, 32'd0);
        flag_wr = 1; flag_wdata = 1; @(negedge clk); flag_wr = 0;
        check("R9", "flag written 1", {31'd0, ovf_flag}, 32'd1);
        flag_wr = 1; flag_wdata = 0; @(negedge clk); flag_wr = 0;
        m_flag = 1'b0;

        // Random scenarios (R1..R6, R11)
        for (int it = 0; it < 24; it++) begin
            bit s   = 1'($urandom % 2);
            bit sn  = 1'($urandom % 2);
            bit slp = 1'($urandom % 2);
            logic [1:0] ps = 2'($urandom % 4);
            logic [15:0] v = (it % 4 == 0) ? 16'hFFF8 : 16'($urandom);
            cfg(s, sn, ps, slp);
            load(v);
            if (s) run_ext(1 + int'($urandom % 12));
            else   run_int(1 + int'($urandom % 16));
            check_state(s ? (slp && !sn ? "R5" : "R3") : "R1");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule